// File: doc/BRIEF.md
# Write-Through Invalidate Snoop Controller

This block keeps the coherence state of a small direct-mapped data cache that sits on a shared snooping bus. Writes always go through to memory, and a write that misses leaves the cache untouched. Each line is either valid or invalid. The controller accepts one processor read or write at a time. It turns misses and all writes into bus transactions. It watches every transaction on the shared bus, so that a write from another agent removes any stale local copy of that address.

Each line holds one data word. An address splits into a line index (the low `IDX_W` bits) and a tag (the remaining upper bits). The bus side is a request/grant/acknowledge handshake. The snoop side observes each bus transaction together with the identifier of the agent that issued it. Because every agent observes the same transaction stream, the shared bus is the only point where accesses are ordered.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every line becomes invalid, `cpu_ready` is high afterwards, and `bus_req` and `cpu_done` are low.
- R2: A processor read whose line is invalid, or whose tag differs, issues one bus read. The word returned with `bus_ack` is delivered on `cpu_rdata` and stored, and the line becomes valid.
- R3: A processor read to a valid line with a matching tag issues no bus transaction. It returns the locally held word in the cycle after acceptance.
- R4: Every processor write issues a bus write carrying its address and data. If the line is valid with a matching tag, the local word is replaced by the written data and the line stays valid.
- R5: A processor write that misses does not allocate. The line keeps its previous state and contents.
- R6: A snooped write from another agent invalidates a valid line whose index and tag both match. A snooped read, or a write whose tag differs, changes nothing.
- R7: Snooped transactions whose source identifier equals `AGENT_ID` are ignored.
- R8: Only one request is handled at a time. `cpu_ready` stays low from acceptance until the response cycle has ended. `bus_req` stays high until `bus_gnt` is seen.
- R9: When a snooped write and a processor access hit the same line in the same cycle, the snoop takes effect first. A read in that cycle therefore goes to the bus.
- R10: `bus_cmd` encodes 2'b00 idle, 2'b01 read and 2'b10 write, and it is non-idle only while a transaction is pending. `cpu_done` is a one-cycle pulse in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_done | output | 1 | Response cycle pulse |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_done` is high after a read |
| bus_req | output | 1 | Bus request, held until granted |
| bus_cmd | output | 2 | Pending bus command (00 idle, 01 read, 10 write) |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_ack | input | 1 | Transaction completes this cycle |
| bus_rdata | input | DATA_W | Bus read data, valid with `bus_ack` |
| snp_valid | input | 1 | An observed bus transaction is present |
| snp_cmd | input | 2 | Observed command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Observed address |
| snp_src | input | SRC_W | Identifier of the issuing agent |

## Verification
On every cycle, the in-line assertions check these properties: the request and ready handshake, that the bus command is legal while a request is held, that `cpu_done` is a single pulse, and that accepted writes always reach the bus. They also check that a fill leaves its line valid, that a qualifying foreign snoop clears its line, and that snoops from this agent never lower the valid count. Only the bench's scenarios can show the data results: the word returned after hits, misses and write-through updates, that a write miss leaves the line as it was, that other-tag or read snoops leave a line alone, and that a snoop in the same cycle as a read turns that read into a bus read.

// File: rtl/wtsc_pkg.sv
// Shared encodings for the write-through snoop controller.
// Assumes a two-bit bus command field shared by the master and snoop sides.
package wtsc_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE = 2'b00,
        BUS_RD   = 2'b01,
        BUS_WR   = 2'b10
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GNT,
        ST_XFER,
        ST_RESP
    } req_state_e;
endpackage

// File: rtl/wtsc_line_array.sv
// Line state, tag and data storage for a direct-mapped write-through cache.
// Two read ports (processor lookup and snoop lookup) act as duplicate tags.
// Write priority per line: fill, then snoop invalidate; an update touches data only.
module wtsc_line_array #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 8,
    localparam int LINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  sn_idx,
    output logic [TAG_W-1:0]  sn_tag,
    input  logic              inv_en,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] upd_data,
    output logic [LINES-1:0]  valid_vec
);
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [LINES-1:0]  valid_q;

    // Valid bits: reset clears, fill sets, qualifying snoop clears.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n)
                valid_q[i] <= 1'b0;
            else if (fill_en && wr_idx == IDX_W'(i))
                valid_q[i] <= 1'b1;
            else if (inv_en && sn_idx == IDX_W'(i))
                valid_q[i] <= 1'b0;
        end
    end

    // Tag and data storage: fill writes both, a write hit replaces the data.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (fill_en && wr_idx == IDX_W'(i)) begin
                tag_q[i]  <= fill_tag;
                data_q[i] <= fill_data;
            end else if (upd_en && wr_idx == IDX_W'(i)) begin
                data_q[i] <= upd_data;
            end
        end
    end

    // Read ports.
    always_comb begin
        lk_tag    = tag_q[lk_idx];
        lk_data   = data_q[lk_idx];
        sn_tag    = tag_q[sn_idx];
        valid_vec = valid_q;
    end

    // A fill always leaves its line valid in the next cycle.
    p_fill_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_vec[$past(wr_idx)]);

    // A snoop invalidate not overridden by a fill clears the line.
    p_snoop_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !(fill_en && wr_idx == sn_idx)) |=> !valid_vec[$past(sn_idx)]);
endmodule

// File: rtl/wtsc_snoop_filter.sv
// Decides whether an observed bus transaction invalidates a local line.
// Assumes snoops carry the issuer's identifier; this agent's own traffic is dropped.
module wtsc_snoop_filter
    import wtsc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 4,
    parameter int SRC_W    = 2,
    parameter int AGENT_ID = 0,
    localparam int TAG_W   = ADDR_W - IDX_W,
    localparam int LINES   = 1 << IDX_W
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [SRC_W-1:0]  snp_src,
    input  logic [LINES-1:0]  valid_vec,
    input  logic [TAG_W-1:0]  line_tag,
    output logic [IDX_W-1:0]  sn_idx,
    output logic              inv_en
);
    logic foreign;
    logic is_wr;

    // Qualify: foreign write that matches a valid line's tag.
    always_comb begin
        sn_idx  = snp_addr[IDX_W-1:0];
        foreign = (snp_src != SRC_W'(AGENT_ID));
        is_wr   = (bus_cmd_e'(snp_cmd) == BUS_WR);
        inv_en  = snp_valid && foreign && is_wr && valid_vec[sn_idx]
                  && (line_tag == snp_addr[ADDR_W-1:IDX_W]);
    end
endmodule

// File: rtl/wtsc_req_fsm.sv
// Processor-side sequencer: accepts one request, serves read hits locally,
// sends misses and all writes over the bus, and produces a one-cycle response.
// Assumes bus_ack only arrives after the grant, while the transfer is pending.
module wtsc_req_fsm
    import wtsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              idle,
    output logic [ADDR_W-1:0] req_addr,
    output logic              fill_en,
    output logic              upd_en
);
    req_state_e        state_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // State transitions and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cpu_req) begin
                    we_q    <= cpu_we;
                    addr_q  <= cpu_addr;
                    wdata_q <= cpu_wdata;
                    if (!cpu_we && lk_hit) begin
                        rdata_q <= lk_data;
                        state_q <= ST_RESP;
                    end else begin
                        state_q <= ST_GNT;
                    end
                end
                ST_GNT:  if (bus_gnt) state_q <= ST_XFER;
                ST_XFER: if (bus_ack) begin
                    if (!we_q) rdata_q <= bus_rdata;
                    state_q <= ST_RESP;
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state and captured request.
    always_comb begin
        idle      = (state_q == ST_IDLE);
        cpu_ready = idle;
        cpu_done  = (state_q == ST_RESP);
        cpu_rdata = rdata_q;
        bus_req   = (state_q == ST_GNT);
        bus_addr  = addr_q;
        bus_wdata = wdata_q;
        req_addr  = addr_q;
        if (state_q == ST_GNT || state_q == ST_XFER)
            bus_cmd = we_q ? BUS_WR : BUS_RD;
        else
            bus_cmd = BUS_IDLE;
        fill_en   = (state_q == ST_XFER) && bus_ack && !we_q;
        upd_en    = (state_q == ST_XFER) && bus_ack && we_q && lk_hit;
    end

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || cpu_done) |-> !cpu_ready);

    p_cmd_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd == BUS_RD || bus_cmd == BUS_WR));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
endmodule

// File: rtl/wt_snoop_ctrl.sv
// Top of the write-through, no-write-allocate, valid/invalid snoop controller.
// Connects the request sequencer, the snoop filter and the line array, and
// orders a same-cycle snoop ahead of the processor lookup on the same line.
module wt_snoop_ctrl
    import wtsc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 4,
    parameter int DATA_W   = 8,
    parameter int SRC_W    = 2,
    parameter int AGENT_ID = 0,
    localparam int TAG_W   = ADDR_W - IDX_W,
    localparam int LINES   = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [SRC_W-1:0]  snp_src
);
    logic              idle;
    logic [ADDR_W-1:0] req_addr;
    logic [ADDR_W-1:0] lk_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              lk_hit;
    logic [IDX_W-1:0]  sn_idx;
    logic [TAG_W-1:0]  sn_tag;
    logic              inv_en;
    logic              fill_en;
    logic              upd_en;
    logic [LINES-1:0]  valid_vec;

    // Lookup address: incoming request when idle, captured request otherwise;
    // a same-cycle invalidate of that line counts as a miss (snoop first).
    always_comb begin
        lk_addr = idle ? cpu_addr : req_addr;
        lk_idx  = lk_addr[IDX_W-1:0];
        lk_hit  = valid_vec[lk_idx] && (lk_tag == lk_addr[ADDR_W-1:IDX_W])
                  && !(inv_en && sn_idx == lk_idx);
    end

    wtsc_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .lk_hit(lk_hit), .lk_data(lk_data),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .idle(idle), .req_addr(req_addr), .fill_en(fill_en), .upd_en(upd_en)
    );

    wtsc_snoop_filter #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SRC_W(SRC_W),
                        .AGENT_ID(AGENT_ID)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_src(snp_src),
        .valid_vec(valid_vec), .line_tag(sn_tag), .sn_idx(sn_idx), .inv_en(inv_en)
    );

    wtsc_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_data(lk_data),
        .sn_idx(sn_idx), .sn_tag(sn_tag), .inv_en(inv_en),
        .fill_en(fill_en), .wr_idx(lk_idx), .fill_tag(lk_addr[ADDR_W-1:IDX_W]),
        .fill_data(bus_rdata), .upd_en(upd_en), .upd_data(bus_wdata),
        .valid_vec(valid_vec)
    );

    // Reset leaves every line invalid and no bus request.
    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0 && !bus_req && !cpu_done));

    // An accepted write always turns into a bus write.
    p_write_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_we) |=> (bus_req && bus_cmd == BUS_WR));

    // An accepted read hit makes no bus request.
    p_hit_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we && lk_hit) |=> (!bus_req && cpu_done));

    // Own-source snoops never reduce the number of valid lines.
    p_own_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_src == SRC_W'(AGENT_ID))
        |=> ($countones(valid_vec) >= $past($countones(valid_vec))));
endmodule

// File: tb/wt_snoop_ctrl_test.sv
// Self-checking bench: vector table walked by one loop, then directed cases.
module wt_snoop_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam int DW = 8;
    localparam int SW = 2;
    localparam int ME = 1;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready, cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_gnt = 1'b0, bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'b00;
    logic [AW-1:0] snp_addr = '0;
    logic [SW-1:0] snp_src = '0;

    logic [DW-1:0] mem [1 << AW];
    int            n_checks = 0, n_fail = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .SRC_W(SW), .AGENT_ID(ME)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_src(snp_src)
    );

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [1:0]    cmd;    // expected bus command: 0 none, 1 read, 2 write
        logic          chk;    // compare read data
        logic [DW-1:0] rdata;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h10, 8'h00, 2'd1, 1'b1, 8'h4A},  // R2 miss fill
        '{1'b0, 8'h10, 8'h00, 2'd0, 1'b1, 8'h4A},  // R3 hit
        '{1'b1, 8'h10, 8'h33, 2'd2, 1'b0, 8'h00},  // R4 write hit
        '{1'b0, 8'h10, 8'h00, 2'd0, 1'b1, 8'h33},  // R4 R7 local copy updated, own echo ignored
        '{1'b1, 8'h21, 8'h77, 2'd2, 1'b0, 8'h00},  // R5 write miss
        '{1'b0, 8'h21, 8'h00, 2'd1, 1'b1, 8'h77},  // R5 not allocated
        '{1'b0, 8'h14, 8'h00, 2'd1, 1'b1, 8'h4E},  // R2 tag conflict
        '{1'b0, 8'h10, 8'h00, 2'd1, 1'b1, 8'h33},  // R2 refetch
        '{1'b0, 8'h21, 8'h00, 2'd0, 1'b1, 8'h77},  // R3 hit
        '{1'b1, 8'h35, 8'h99, 2'd2, 1'b0, 8'h00},  // R5 write miss other tag
        '{1'b0, 8'h21, 8'h00, 2'd0, 1'b1, 8'h77}   // R5 line untouched
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            check(1'b0, "watchdog", cycles, WATCHDOG);
            finish_run();
        end
    end

    // One processor access with arbiter and memory emulation.
    // same_snp: drive a foreign write of snp_data to the same address in the accept cycle.
    task automatic access(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                          input int gnt_dly, input bit same_snp, input logic [DW-1:0] snp_data,
                          output logic [1:0] seen, output logic [DW-1:0] rd);
        seen = 2'd0;
        rd   = '0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        if (same_snp) begin
            snp_valid = 1'b1; snp_cmd = 2'b10; snp_addr = addr; snp_src = 2'd2;
            mem[addr] = snp_data;
        end
        @(negedge clk);
        cpu_req = 1'b0; snp_valid = 1'b0;
        for (int guard = 0; guard < 100; guard++) begin
            if (cpu_done) begin
                rd = cpu_rdata;
                @(negedge clk);
                check(!cpu_done && cpu_ready, "R10 done pulse", cpu_done, 0);
                return;
            end
            if (bus_req) begin
                seen = bus_cmd;
                for (int d = 0; d < gnt_dly; d++) begin
                    check(bus_req && !cpu_ready, "R8 held until grant", {bus_req, cpu_ready}, 2);
                    @(negedge clk);
                end
                bus_gnt = 1'b1;
                @(negedge clk);
                bus_gnt = 1'b0;
                check(!cpu_ready && !bus_req, "R8 transfer pending", {bus_req, cpu_ready}, 0);
                bus_ack = 1'b1;
                bus_rdata = mem[addr];
                snp_valid = 1'b1; snp_cmd = bus_cmd; snp_addr = addr; snp_src = SW'(ME);
                if (we) mem[addr] = wd;
                @(negedge clk);
                bus_ack = 1'b0; snp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        check(1'b0, "R8 no response", 0, 1);
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] addr,
                         input logic [DW-1:0] d, input logic [SW-1:0] src);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr; snp_src = src;
        if (cmd == 2'b10 && src != SW'(ME)) mem[addr] = d;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic expect_read(input logic [AW-1:0] addr, input logic [1:0] cmd,
                               input logic [DW-1:0] data, input string req);
        logic [1:0] s;
        logic [DW-1:0] r;
        access(1'b0, addr, '0, 0, 1'b0, '0, s, r);
        check(s == cmd, req, s, cmd);
        check(r == data, req, r, data);
    endtask

    initial begin
        logic [1:0]    s;
        logic [DW-1:0] r;
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i) ^ 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(cpu_ready && !bus_req && !cpu_done && bus_cmd == 2'b00, "R1 reset outputs",
              {cpu_ready, bus_req, cpu_done}, 4);
        rst_n = 1'b1;

        // Vector table: R2 R3 R4 R5 R7 R10
        for (int v = 0; v < NV; v++) begin
            access(VECS[v].we, VECS[v].addr, VECS[v].wdata, v % 3, 1'b0, '0, s, r);
            check(s == VECS[v].cmd, $sformatf("R10 vector %0d bus cmd", v), s, VECS[v].cmd);
            if (VECS[v].chk)
                check(r == VECS[v].rdata, $sformatf("R2 R3 vector %0d data", v), r, VECS[v].rdata);
        end

        // R6 foreign write with matching tag invalidates
        snoop(2'b10, 8'h10, 8'hC4, 2'd2);
        expect_read(8'h10, 2'd1, 8'hC4, "R6 invalidated by foreign write");
        // R6 foreign write, other tag, same index
        snoop(2'b10, 8'h14, 8'h01, 2'd0);
        expect_read(8'h10, 2'd0, 8'hC4, "R6 other tag ignored");
        // R6 foreign read has no effect
        snoop(2'b01, 8'h10, 8'h00, 2'd3);
        expect_read(8'h10, 2'd0, 8'hC4, "R6 foreign read ignored");
        // R7 own-source write snoop ignored
        snoop(2'b10, 8'h10, 8'hEE, SW'(ME));
        expect_read(8'h10, 2'd0, 8'hC4, "R7 own snoop ignored");

        // R9 snoop and read to the same line in the same cycle
        access(1'b0, 8'h21, '0, 0, 1'b1, 8'h55, s, r);
        check(s == 2'd1, "R9 snoop first forces bus read", s, 1);
        check(r == 8'h55, "R9 fresh data", r, 8'h55);

        // R8 slow grant
        access(1'b0, 8'h16, '0, 4, 1'b0, '0, s, r);
        check(s == 2'd1 && r == 8'h4C, "R8 slow grant read", r, 8'h4C);
        // R4 write hit then local read
        access(1'b1, 8'h16, 8'hAB, 0, 1'b0, '0, s, r);
        check(s == 2'd2, "R4 write through", s, 2);
        expect_read(8'h16, 2'd0, 8'hAB, "R4 local copy updated");

        // R1 mid-run reset clears all lines
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(cpu_ready && !bus_req, "R1 ready after reset", cpu_ready, 1);
        expect_read(8'h16, 2'd1, 8'hAB, "R1 lines invalid after reset");

        finish_run();
    end
endmodule